// File: doc/BRIEF.md
# ECC Read Error Response Controller

This block sits on the read-data return path between a memory controller's ECC checker and the processor core. For every data beat that arrives, it receives the checker's verdict (clean, single-bit error or multi-bit error), both the raw and the corrected version of the beat, the kind of access that fetched it, and three policy bits held in configuration: a master ECC enable, a single-bit report enable and a single-bit fix enable. It applies the policy and returns the data that the core should consume, together with any interrupt request or abort the beat calls for.

Each beat of a burst is judged on its own, so one burst can raise several events. When an uncorrectable error is found, the kind of abort depends on the access. A data read gives an imprecise data abort. An instruction fetch gives a prefetch abort. A translation-table walk gives a precise data abort. Whenever ECC is enabled and a beat carries any error, the block also emits an event strobe with the beat's address, so that a separate logger can record it.

Every result is registered. Data, interrupt, aborts and event all appear together in the cycle after the beat is accepted. Interrupt, aborts and event are single-cycle pulses.

Top module: `ecc_read_resp`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_vld`, `irq_req`, all three abort outputs and `evt_vld` are low.
- R2: `rsp_vld` is high in exactly the cycle after a cycle with `beat_vld` high, and low otherwise; one response per beat.
- R3: `rsp_data` equals `fix_data` when the beat had `err_cls` = 1 (single-bit), `cfg_ecc_en` = 1 and `cfg_sb_fix` = 1; for every other beat it equals `raw_data`.
- R4: With `cfg_ecc_en` = 0, a beat of any error class raises no interrupt, no abort and no event, and its raw data is forwarded.
- R5: `irq_req` pulses for one cycle after a beat only when that beat had `err_cls` = 1, `cfg_ecc_en` = 1 and `cfg_sb_report` = 1.
- R6: A beat with a multi-bit error (`err_cls` = 2, or 3, which is treated as multi-bit) and `cfg_ecc_en` = 1 raises `abort_imprecise` when `xact_kind` is 0 (data read) or 3 (treated as data read).
- R7: Under the same conditions with `xact_kind` = 1 (instruction fetch), `abort_prefetch` is raised instead.
- R8: Under the same conditions with `xact_kind` = 2 (table walk), `abort_precise` is raised instead.
- R9: At most one abort output is high in any cycle, and clean or single-bit beats never raise an abort.
- R10: `evt_vld` pulses after every beat with `cfg_ecc_en` = 1 and `err_cls` ≠ 0; in that cycle `evt_addr` holds the beat's address and `evt_multi` is 1 exactly when the class was multi-bit.
- R11: Beats accepted on consecutive cycles each produce their own response in consecutive cycles, with no merging or loss of pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ecc_en | input | 1 | Master ECC checking enable |
| cfg_sb_report | input | 1 | Request interrupt on single-bit errors |
| cfg_sb_fix | input | 1 | Forward corrected data on single-bit errors |
| beat_vld | input | 1 | A data beat is presented this cycle |
| err_cls | input | 2 | 0 clean, 1 single-bit, 2/3 multi-bit |
| xact_kind | input | 2 | 0/3 data read, 1 instruction fetch, 2 table walk |
| beat_addr | input | ADDR_W | Address of the beat |
| raw_data | input | DATA_W | Data as read from memory |
| fix_data | input | DATA_W | Data after single-bit correction |
| rsp_vld | output | 1 | Response beat valid |
| rsp_data | output | DATA_W | Data forwarded to the core |
| irq_req | output | 1 | Interrupt request pulse |
| abort_imprecise | output | 1 | Imprecise data abort pulse |
| abort_prefetch | output | 1 | Prefetch abort pulse |
| abort_precise | output | 1 | Precise data abort pulse |
| evt_vld | output | 1 | Error event strobe for a logger |
| evt_addr | output | ADDR_W | Address of the erroneous beat |
| evt_multi | output | 1 | Event was a multi-bit error |

## Verification
All of this block's results appear exactly one clock after the beat is sampled: data, valid, interrupt, the three aborts and the event strobe. None of them comes earlier or later. The bench drives each beat on a falling edge. It computes that beat's expected response from the requirements at that point. It then compares every output on the next falling edge, half a period after the rising edge that registers the result. Idle cycles between beats are checked in the same way, to confirm that no pulse survives for more than one cycle.

// File: rtl/ecc_resp_pkg.sv
// Shared encodings for the ECC read error response controller.
// Assumes a 2-bit error class from the checker and a 2-bit access kind.
package ecc_resp_pkg;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_MULTI  = 2'd2,
        ERR_MULTI2 = 2'd3
    } err_cls_e;

    typedef enum logic [1:0] {
        XK_DATA  = 2'd0,
        XK_FETCH = 2'd1,
        XK_WALK  = 2'd2,
        XK_DATA2 = 2'd3
    } xact_kind_e;

    // Notification set produced for one beat.
    typedef struct packed {
        logic irq;
        logic ab_imprecise;
        logic ab_prefetch;
        logic ab_precise;
        logic evt;
        logic evt_multi;
    } resp_t;

endpackage

// File: rtl/ecc_resp_decide.sv
// Policy decision for one beat: applies the enable, report and fix bits
// to the error class and the access kind. Purely combinational.
// Assumes err_cls 3 means multi-bit and xact_kind 3 means data read.
module ecc_resp_decide
    import ecc_resp_pkg::*;
(
    input  logic       beat_vld,
    input  logic [1:0] err_cls,
    input  logic [1:0] xact_kind,
    input  logic       ecc_en,
    input  logic       sb_report,
    input  logic       sb_fix,
    output logic       use_fix,
    output resp_t      resp
);

    err_cls_e   cls;
    xact_kind_e kind;
    logic       is_sb;
    logic       is_mb;

    // Decode the incoming codes into enum values.
    always_comb begin
        cls   = err_cls_e'(err_cls);
        kind  = xact_kind_e'(xact_kind);
        is_sb = (cls == ERR_SINGLE);
        is_mb = (cls == ERR_MULTI) || (cls == ERR_MULTI2);
    end

    // Choose the data source for the beat.
    always_comb begin
        use_fix = ecc_en && sb_fix && is_sb;
    end

    // Build the notifications that the policy allows.
    always_comb begin
        resp = '0;
        if (beat_vld && ecc_en) begin
            resp.irq       = is_sb && sb_report;
            resp.evt       = is_sb || is_mb;
            resp.evt_multi = is_mb;
            if (is_mb) begin
                unique case (kind)
                    XK_FETCH: resp.ab_prefetch  = 1'b1;
                    XK_WALK:  resp.ab_precise   = 1'b1;
                    default:  resp.ab_imprecise = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/ecc_resp_datasel.sv
// Per-lane selection between raw and corrected data.
// Assumes DATA_W is a multiple of LANE_W; every lane follows the same select.
module ecc_resp_datasel #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic              use_fix,
    input  logic [DATA_W-1:0] raw_data,
    input  logic [DATA_W-1:0] fix_data,
    output logic [DATA_W-1:0] sel_data
);

    localparam int LANES = DATA_W / LANE_W;

    // One mux per lane, so each one can be placed next to its data slice.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sel_data[l*LANE_W +: LANE_W] = use_fix ? fix_data[l*LANE_W +: LANE_W]
                                                      : raw_data[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/ecc_resp_stage.sv
// Output register stage: holds the response for exactly one cycle.
// Assumes the notification set is zero for cycles with no beat.
module ecc_resp_stage
    import ecc_resp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_vld,
    input  logic [DATA_W-1:0] sel_data,
    input  logic [ADDR_W-1:0] beat_addr,
    input  resp_t             resp,
    output logic              vld_q,
    output logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] addr_q,
    output resp_t             resp_q
);

    // Valid flag and notification pulses, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            resp_q <= '0;
        end else begin
            vld_q  <= beat_vld;
            resp_q <= resp;
        end
    end

    // Data and address captured only when a beat is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            addr_q <= '0;
        end else if (beat_vld) begin
            data_q <= sel_data;
            addr_q <= beat_addr;
        end
    end

    // At most one abort kind per response.
    assert_one_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_q.ab_imprecise, resp_q.ab_prefetch, resp_q.ab_precise}));

    // A pulse never lasts past the cycle after its beat.
    assert_pulse_needs_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_q != '0) |-> vld_q);

endmodule

// File: rtl/ecc_read_resp.sv
// Top of the ECC read error response controller. Applies the policy to
// each beat and returns data plus notification pulses one cycle later.
// Assumes the checker supplies class and corrected data in the beat cycle.
module ecc_read_resp
    import ecc_resp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ecc_en,
    input  logic              cfg_sb_report,
    input  logic              cfg_sb_fix,
    input  logic              beat_vld,
    input  logic [1:0]        err_cls,
    input  logic [1:0]        xact_kind,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [DATA_W-1:0] raw_data,
    input  logic [DATA_W-1:0] fix_data,
    output logic              rsp_vld,
    output logic [DATA_W-1:0] rsp_data,
    output logic              irq_req,
    output logic              abort_imprecise,
    output logic              abort_prefetch,
    output logic              abort_precise,
    output logic              evt_vld,
    output logic [ADDR_W-1:0] evt_addr,
    output logic              evt_multi
);

    logic              use_fix;
    resp_t             resp;
    resp_t             resp_q;
    logic [DATA_W-1:0] sel_data;

    ecc_resp_decide u_decide (
        .beat_vld  (beat_vld),
        .err_cls   (err_cls),
        .xact_kind (xact_kind),
        .ecc_en    (cfg_ecc_en),
        .sb_report (cfg_sb_report),
        .sb_fix    (cfg_sb_fix),
        .use_fix   (use_fix),
        .resp      (resp)
    );

    ecc_resp_datasel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_datasel (
        .use_fix  (use_fix),
        .raw_data (raw_data),
        .fix_data (fix_data),
        .sel_data (sel_data)
    );

    ecc_resp_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .beat_vld  (beat_vld),
        .sel_data  (sel_data),
        .beat_addr (beat_addr),
        .resp      (resp),
        .vld_q     (rsp_vld),
        .data_q    (rsp_data),
        .addr_q    (evt_addr),
        .resp_q    (resp_q)
    );

    // Unpack the registered notification set onto the ports.
    always_comb begin
        irq_req         = resp_q.irq;
        abort_imprecise = resp_q.ab_imprecise;
        abort_prefetch  = resp_q.ab_prefetch;
        abort_precise   = resp_q.ab_precise;
        evt_vld         = resp_q.evt;
        evt_multi       = resp_q.evt_multi;
    end

    assert_valid_follows_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld == $past(beat_vld));

    assert_silent_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg_ecc_en) |-> !(irq_req || abort_imprecise || abort_prefetch
                                 || abort_precise || evt_vld));

    assert_irq_single_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(beat_vld && err_cls == 2'd1 && cfg_ecc_en && cfg_sb_report));

    assert_fetch_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_prefetch |-> $past(xact_kind == 2'd1 && err_cls[1]));

    assert_walk_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_precise |-> $past(xact_kind == 2'd2 && err_cls[1]));

    assert_event_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_vld |-> (evt_addr == $past(beat_addr)));

endmodule

// File: tb/ecc_read_resp_tb.sv
module ecc_read_resp_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_ecc_en = 1'b0, cfg_sb_report = 1'b0, cfg_sb_fix = 1'b0;
    logic          beat_vld = 1'b0;
    logic [1:0]    err_cls = '0, xact_kind = '0;
    logic [AW-1:0] beat_addr = '0;
    logic [DW-1:0] raw_data = '0, fix_data = '0;
    logic          rsp_vld, irq_req, abort_imprecise, abort_prefetch, abort_precise;
    logic          evt_vld, evt_multi;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] evt_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_read_resp u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en), .cfg_sb_report(cfg_sb_report),
        .cfg_sb_fix(cfg_sb_fix), .beat_vld(beat_vld), .err_cls(err_cls),
        .xact_kind(xact_kind), .beat_addr(beat_addr), .raw_data(raw_data),
        .fix_data(fix_data), .rsp_vld(rsp_vld), .rsp_data(rsp_data), .irq_req(irq_req),
        .abort_imprecise(abort_imprecise), .abort_prefetch(abort_prefetch),
        .abort_precise(abort_precise), .evt_vld(evt_vld), .evt_addr(evt_addr),
        .evt_multi(evt_multi)
    );

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // Expected response of the last driven cycle, computed from the requirements.
    logic          e_vld, e_irq, e_imp, e_pre, e_prc, e_evt, e_mul;
    logic [DW-1:0] e_data;
    logic [AW-1:0] e_addr;
    string         t_ab;

    // Drive one cycle (beat or idle) at a falling edge, compare at the next one.
    task automatic cycle(input logic v, input logic en, input logic rep, input logic fx,
                         input logic [1:0] c, input logic [1:0] k);
        logic sb, mb;
        beat_vld = v; cfg_ecc_en = en; cfg_sb_report = rep; cfg_sb_fix = fx;
        err_cls = c; xact_kind = k;
        beat_addr = $urandom;
        raw_data = {$urandom, $urandom};
        fix_data = raw_data ^ (64'd1 << ($urandom % DW));
        sb = (c == 2'd1);
        mb = (c >= 2'd2);
        e_vld = v;
        if (v) begin
            e_data = (en && sb && fx) ? fix_data : raw_data;
            e_addr = beat_addr;
        end
        e_irq = v && en && sb && rep;
        e_imp = v && en && mb && (k == 2'd0 || k == 2'd3);
        e_pre = v && en && mb && (k == 2'd1);
        e_prc = v && en && mb && (k == 2'd2);
        e_evt = v && en && (sb || mb);
        e_mul = v && en && mb;
        t_ab = (k == 2'd1) ? "R7" : (k == 2'd2) ? "R8" : "R6";
        @(negedge clk);
        chk(DW'(rsp_vld), DW'(e_vld), "R2 rsp_vld");
        if (v) chk(rsp_data, e_data, en ? "R3 rsp_data" : "R4 rsp_data");
        chk(DW'(irq_req), DW'(e_irq), en ? "R5 irq_req" : "R4 irq_req");
        chk(DW'(abort_imprecise), DW'(e_imp), en ? "R6 abort_imprecise" : "R4 abort");
        chk(DW'(abort_prefetch), DW'(e_pre), en ? "R7 abort_prefetch" : "R4 abort");
        chk(DW'(abort_precise), DW'(e_prc), en ? "R8 abort_precise" : "R4 abort");
        chk(DW'($countones({abort_imprecise, abort_prefetch, abort_precise})),
            DW'(e_imp || e_pre || e_prc), {"R9 abort count ", t_ab});
        chk(DW'(evt_vld), DW'(e_evt), en ? "R10 evt_vld" : "R4 evt_vld");
        if (e_evt) begin
            chk(DW'(evt_addr), DW'(e_addr), "R10 evt_addr");
            chk(DW'(evt_multi), DW'(e_mul), "R10 evt_multi");
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(DW'({rsp_vld, irq_req, abort_imprecise, abort_prefetch, abort_precise, evt_vld}),
            '0, "R1 reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        chk(DW'({rsp_vld, irq_req, abort_imprecise, abort_prefetch, abort_precise, evt_vld}),
            '0, "R1 after reset");
        // R11: every policy, class and kind combination back to back.
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 4; c++)
                for (int k = 0; k < 4; k++)
                    cycle(1'b1, p[0], p[1], p[2], 2'(c), 2'(k));
        cycle(1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'd0);
        // Same combinations with idle gaps: pulses must end after one cycle.
        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 4; c++) begin
                cycle(1'b1, p[0], p[1], p[2], 2'(c), 2'(c ^ p[1:0]));
                cycle(1'b0, p[0], p[1], p[2], 2'(c), 2'd0);
            end
        // R11: random mix of bursts and gaps.
        for (int i = 0; i < 400; i++)
            cycle(1'($urandom % 4 != 0), 1'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom), 2'($urandom));
        cycle(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule